// File: doc/BRIEF.md
# Two-Strike Timer Watchdog

This block pairs a down-counting timer with a watchdog monitor. Both sit behind a single-cycle register port. The timer counts enabled cycles of a tick input, which stands in for a 1 MHz timebase. Each time its period runs out, it raises an interrupt flag. Software acknowledges the interrupt by writing a clear register.

The watchdog reacts only to a second expiry that arrives while the interrupt from the previous expiry is still unacknowledged. In that case it drives a system reset output. A single missed acknowledge therefore raises only the interrupt. For a watchdog timeout of T seconds, software programs a timer period of T × 1,000,000 / 2 ticks, so that two periods span the timeout.

Three registers are visible. The timer word at 0x0 carries the enable, the auto-reload mode and the period. The acknowledge word at 0x4 clears the pending flag on write and shows it on read. The watchdog word at 0x8 carries the watchdog enable, the source select and the reset-action enable. Read data is registered and appears the cycle after the address is presented.

Top module: `strike_wdt`

## Requirements
- R1: After a synchronous reset, irq_o and sys_rst_o are 0, and every register reads back 0.
- R2: Register fields read back as written. The timer word at 0x0 has bit 31 = run, bit 30 = auto-reload and bits 28:0 = period. The watchdog word at 0x8 has bit 5 = watchdog on, bit 4 = source select (0 = this timer) and bit 2 = reset action. All other bits read 0.
- R3: While the watchdog is on, a timer started with period P (P ≥ 1) expires at the P-th tick after the write, and irq_o goes to 1 on that edge.
- R4: Writing bit 30 = 1 to 0x4 clears the pending flag, and irq_o drops. Reading 0x4 returns the pending flag in bit 30 and 0 elsewhere.
- R5: An expiry that arrives while the flag is still pending asserts sys_rst_o on that edge, when the watchdog is on, the source is 0 and the reset action is on.
- R6: With RST_HOLD = 0, sys_rst_o is a one-cycle pulse for each strike. With RST_HOLD = 1, it stays high until the next synchronous reset.
- R7: If each expiry is acknowledged before the next one arrives, sys_rst_o never asserts.
- R8: While the watchdog-on bit is 0, the pending flag is cleared on the following edge and no reset can occur.
- R9: With the reset-action bit at 0, repeated unacknowledged expiries keep irq_o high but never assert sys_rst_o.
- R10: With the source-select bit at 1, expiries of this timer never assert sys_rst_o.
- R11: With auto-reload at 0, the timer expires once and then clears its run bit (bit 31 of 0x0 reads 0).
- R12: Writing 0x0 with bit 31 = 0 stops the timer, and no further expiries occur.
- R13: An acknowledge write on the same edge as a second expiry prevents the reset. The flag is then set again by that expiry.
- R14: In auto-reload mode, expiries repeat every P ticks, including when ticks are sparse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle timebase enable |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Timer interrupt pending |
| sys_rst_o | output | 1 | Watchdog system reset |

## Verification
The hardest situation to reach is an acknowledge that lands on exactly the same edge as the second expiry. The bench runs the tick on every cycle, waits until the first interrupt is visible, then counts P-1 further cycles before issuing the clear write, so that the write edge coincides with the expiry edge. A behavioural model, updated on every clock, also follows sparse-tick phases, so it covers reload timing that directed waits do not pin down.

// File: rtl/strike_wdt_pkg.sv
package strike_wdt_pkg;
  localparam int OFS_TMR     = 0;
  localparam int OFS_ACK     = 4;
  localparam int OFS_WD      = 8;
  localparam int TMR_RUN_BIT = 31;
  localparam int TMR_RLD_BIT = 30;
  localparam int ACK_BIT     = 30;
  localparam int WD_ON_BIT   = 5;
  localparam int WD_SRC_BIT  = 4;
  localparam int WD_ACT_BIT  = 2;

  typedef enum logic [1:0] {SEL_TMR, SEL_ACK, SEL_WD, SEL_NONE} reg_sel_e;
endpackage

// File: rtl/wdt_regdec.sv
module wdt_regdec
  import strike_wdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] tmr_word_i,
  input  logic [DATA_W-1:0] ack_word_i,
  input  logic [DATA_W-1:0] wd_word_i,
  output logic              wr_tmr_o,
  output logic              wr_ack_o,
  output logic              wr_wd_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e sel;

  always_comb begin
    if (addr_i == ADDR_W'(OFS_TMR))      sel = SEL_TMR;
    else if (addr_i == ADDR_W'(OFS_ACK)) sel = SEL_ACK;
    else if (addr_i == ADDR_W'(OFS_WD))  sel = SEL_WD;
    else                                 sel = SEL_NONE;
  end

  assign wr_tmr_o = wr_i && (sel == SEL_TMR);
  assign wr_ack_o = wr_i && (sel == SEL_ACK);
  assign wr_wd_o  = wr_i && (sel == SEL_WD);

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else begin
      case (sel)
        SEL_TMR: rdata_o <= tmr_word_i;
        SEL_ACK: rdata_o <= ack_word_i;
        SEL_WD:  rdata_o <= wd_word_i;
        default: rdata_o <= '0;
      endcase
    end
  end

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_tmr_o, wr_ack_o, wr_wd_o}));
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int PERIOD_W = 29
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_i,
  input  logic                wr_i,
  input  logic                run_d,
  input  logic                rld_d,
  input  logic [PERIOD_W-1:0] period_d,
  output logic                run_o,
  output logic                rld_o,
  output logic [PERIOD_W-1:0] period_o,
  output logic                expire_o
);
  localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

  logic                run_q, rld_q;
  logic [PERIOD_W-1:0] period_q, cnt_q;

  assign expire_o = run_q && tick_i && !wr_i && (cnt_q <= ONE);
  assign run_o    = run_q;
  assign rld_o    = rld_q;
  assign period_o = period_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      rld_q    <= 1'b0;
      period_q <= '0;
      cnt_q    <= '0;
    end else if (wr_i) begin
      run_q    <= run_d;
      rld_q    <= rld_d;
      period_q <= period_d;
      cnt_q    <= period_d;
    end else if (run_q && tick_i) begin
      if (cnt_q <= ONE) begin
        cnt_q <= period_q;
        if (!rld_q) run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  // R11
  oneshot_off_chk: assert property (@(posedge clk) disable iff (rst)
    (expire_o && !rld_q) |=> !run_q);
  // R14
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (expire_o && rld_q) |=> (cnt_q == $past(period_q)));
  // R12
  stop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !run_d) |=> !expire_o);
endmodule

// File: rtl/wdt_strike.sv
module wdt_strike #(
  parameter bit RST_HOLD = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_wd_i,
  input  logic on_d,
  input  logic src_d,
  input  logic act_d,
  input  logic ack_i,
  input  logic expire_i,
  output logic on_o,
  output logic src_o,
  output logic act_o,
  output logic pend_o,
  output logic rst_o
);
  logic on_q, src_q, act_q, pend_q, rst_q, strike;

  assign strike = on_q && !src_q && act_q && expire_i && pend_q && !ack_i;
  assign on_o   = on_q;
  assign src_o  = src_q;
  assign act_o  = act_q;
  assign pend_o = pend_q;
  assign rst_o  = rst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q   <= 1'b0;
      src_q  <= 1'b0;
      act_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_wd_i) begin
        on_q  <= on_d;
        src_q <= src_d;
        act_q <= act_d;
      end
      if (!on_q) pend_q <= 1'b0;
      else       pend_q <= (pend_q && !ack_i) || expire_i;
    end
  end

  generate
    if (RST_HOLD) begin : g_hold
      always_ff @(posedge clk) begin
        if (rst) rst_q <= 1'b0;
        else     rst_q <= rst_q || strike;
      end
      // R6
      rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rst_q |=> rst_q);
    end else begin : g_pulse
      always_ff @(posedge clk) begin
        if (rst) rst_q <= 1'b0;
        else     rst_q <= strike;
      end
    end
  endgenerate

  // R8
  off_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !on_q |=> !pend_q);
  // R5
  strike_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_q) |-> $past(pend_q));
endmodule

// File: rtl/strike_wdt.sv
module strike_wdt
  import strike_wdt_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int PERIOD_W = 29,
  parameter bit RST_HOLD = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              sys_rst_o
);
  logic                wr_tmr, wr_ack, wr_wd;
  logic                run, rld, expire, on, src, act, pend;
  logic [PERIOD_W-1:0] period;
  logic [DATA_W-1:0]   tmr_word, ack_word, wd_word;

  always_comb begin
    tmr_word = '0;
    tmr_word[TMR_RUN_BIT] = run;
    tmr_word[TMR_RLD_BIT] = rld;
    tmr_word[PERIOD_W-1:0] = period;
    ack_word = '0;
    ack_word[ACK_BIT] = pend;
    wd_word = '0;
    wd_word[WD_ON_BIT]  = on;
    wd_word[WD_SRC_BIT] = src;
    wd_word[WD_ACT_BIT] = act;
  end

  wdt_regdec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst(rst), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .tmr_word_i(tmr_word), .ack_word_i(ack_word), .wd_word_i(wd_word),
    .wr_tmr_o(wr_tmr), .wr_ack_o(wr_ack), .wr_wd_o(wr_wd),
    .rdata_o(reg_rdata_o)
  );

  wdt_timer #(.PERIOD_W(PERIOD_W)) u_tmr (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_i(wr_tmr),
    .run_d(reg_wdata_i[TMR_RUN_BIT]), .rld_d(reg_wdata_i[TMR_RLD_BIT]),
    .period_d(reg_wdata_i[PERIOD_W-1:0]),
    .run_o(run), .rld_o(rld), .period_o(period), .expire_o(expire)
  );

  wdt_strike #(.RST_HOLD(RST_HOLD)) u_strike (
    .clk(clk), .rst(rst), .wr_wd_i(wr_wd),
    .on_d(reg_wdata_i[WD_ON_BIT]), .src_d(reg_wdata_i[WD_SRC_BIT]),
    .act_d(reg_wdata_i[WD_ACT_BIT]),
    .ack_i(wr_ack && reg_wdata_i[ACK_BIT]), .expire_i(expire),
    .on_o(on), .src_o(src), .act_o(act), .pend_o(pend), .rst_o(sys_rst_o)
  );

  assign irq_o = pend;

  // R3
  irq_needs_on_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(on));
endmodule

// File: tb/strike_wdt_bench.sv
module strike_wdt_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1, tick = 1, wr = 0;
  logic [3:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata, rdata_h;
  logic        irq, srst, irq_h, srst_h;

  int n_chk = 0, n_fail = 0, cyc = 0, tick_div = 1;
  bit started = 0, rst_seen = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  strike_wdt u_strike_wdt (.clk(clk), .rst(rst), .tick_i(tick), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .sys_rst_o(srst));
  strike_wdt #(.RST_HOLD(1'b1)) u_hold (.clk(clk), .rst(rst), .tick_i(tick),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata_h), .irq_o(irq_h), .sys_rst_o(srst_h));

  // behavioural reference
  int  m_cnt, m_period;
  bit  m_run, m_rld, m_on, m_src, m_act, m_pend, m_rst, m_rst_h;
  logic [31:0] m_rdata;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit exp_now, ack, strike;
    cyc++;
    started = 1;
    if (rst) begin
      m_cnt = 0; m_period = 0; m_run = 0; m_rld = 0; m_on = 0; m_src = 0;
      m_act = 0; m_pend = 0; m_rst = 0; m_rst_h = 0; m_rdata = 0;
    end else begin
      case (addr)
        4'h0: m_rdata = {m_run, m_rld, 1'b0, 29'(m_period)};
        4'h4: m_rdata = 32'(m_pend) << 30;
        4'h8: m_rdata = {26'd0, m_on, m_src, 1'b0, m_act, 2'b00};
        default: m_rdata = 0;
      endcase
      exp_now = m_run && tick && !(wr && addr == 0) && m_cnt <= 1;
      ack = wr && addr == 4 && wdata[30];
      strike = m_on && !m_src && m_act && exp_now && m_pend && !ack;
      m_rst = strike;
      m_rst_h = m_rst_h || strike;
      m_pend = m_on ? ((m_pend && !ack) || exp_now) : 0;
      if (wr && addr == 8) begin
        m_on = wdata[5]; m_src = wdata[4]; m_act = wdata[2];
      end
      if (wr && addr == 0) begin
        m_run = wdata[31]; m_rld = wdata[30];
        m_period = int'(wdata[28:0]); m_cnt = m_period;
      end else if (m_run && tick) begin
        if (m_cnt <= 1) begin
          m_cnt = m_period;
          if (!m_rld) m_run = 0;
        end else m_cnt--;
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk({cur_req, " model irq"}, 32'(irq), 32'(m_pend));
      chk({cur_req, " model rst"}, 32'(srst), 32'(m_rst));
      chk({cur_req, " model rst_hold"}, 32'(srst_h), 32'(m_rst_h));
      chk({cur_req, " model rdata"}, rdata, m_rdata);
      if (srst) rst_seen = 1;
    end
    tick <= (tick_div <= 1) || (cyc % tick_div == 0);
  end

  always @(posedge clk) if (cyc > 20000) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected<20000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask
  task automatic wr_reg(logic [3:0] a, logic [31:0] d);
    wr = 1; addr = a; wdata = d; step(1); wr = 0; addr = 4'hF;
  endtask
  task automatic rd_reg(logic [3:0] a, output logic [31:0] v);
    addr = a; step(1); v = rdata; addr = 4'hF;
  endtask
  task automatic do_reset();
    rst = 1; tick_div = 1; step(2); rst = 0; rst_seen = 0;
  endtask

  initial begin
    logic [31:0] v;
    @(negedge clk);
    do_reset();
    cur_req = "R1";
    chk("R1 irq", 32'(irq), 0); chk("R1 rst", 32'(srst), 0);
    rd_reg(4'h0, v); chk("R1 tmr word", v, 0);
    rd_reg(4'h8, v); chk("R1 wd word", v, 0);

    cur_req = "R2";
    wr_reg(4'h8, 32'h0000_0024);
    wr_reg(4'h0, 32'hC000_0005);
    rd_reg(4'h0, v); chk("R2 tmr word", v, 32'hC000_0005);
    rd_reg(4'h8, v); chk("R2 wd word", v, 32'h0000_0024);

    // R3 / R5 / R6: tick every cycle, P=5
    do_reset(); cur_req = "R3";
    wr_reg(4'h8, 32'h24);
    wr_reg(4'h0, 32'hC000_0005);
    step(4); chk("R3 irq before P ticks", 32'(irq), 0);
    step(1); chk("R3 irq at P ticks", 32'(irq), 1);
    cur_req = "R5";
    step(4); chk("R5 no rst yet", 32'(srst), 0);
    step(1); chk("R5 rst on second expiry", 32'(srst), 1);
    cur_req = "R6";
    step(1); chk("R6 pulse drops", 32'(srst), 0);
    chk("R6 hold variant stays", 32'(srst_h), 1);
    rd_reg(4'h4, v); chk("R4 ack word shows pending", v, 32'h4000_0000);
    cur_req = "R4";
    wr_reg(4'h4, 32'h4000_0000);
    chk("R4 irq cleared", 32'(irq), 0);
    rd_reg(4'h4, v); chk("R4 ack word after clear", v, 0);

    // R13: ack on same edge as second expiry
    do_reset(); cur_req = "R13";
    wr_reg(4'h8, 32'h24);
    wr_reg(4'h0, 32'hC000_0005);
    step(5); chk("R13 first irq", 32'(irq), 1);
    step(4); wr_reg(4'h4, 32'h4000_0000);
    chk("R13 no rst", 32'(srst), 0);
    chk("R13 irq re-set", 32'(irq), 1);

    // R7: acknowledge every period
    do_reset(); cur_req = "R7";
    wr_reg(4'h8, 32'h24);
    wr_reg(4'h0, 32'hC000_0004);
    for (int k = 0; k < 5; k++) begin
      for (int w = 0; w < 20 && !irq; w++) step(1);
      wr_reg(4'h4, 32'h4000_0000);
    end
    chk("R7 never reset", 32'(rst_seen), 0);

    // R8: watchdog off clears pending
    do_reset(); cur_req = "R8";
    wr_reg(4'h8, 32'h24);
    wr_reg(4'h0, 32'hC000_0003);
    step(3); chk("R8 irq set", 32'(irq), 1);
    wr_reg(4'h8, 32'h0); step(1);
    chk("R8 irq cleared by off", 32'(irq), 0);
    step(12); chk("R8 no rst", 32'(rst_seen), 0);

    // R9: reset action off
    do_reset(); cur_req = "R9";
    wr_reg(4'h8, 32'h20);
    wr_reg(4'h0, 32'hC000_0003);
    step(12);
    chk("R9 irq held", 32'(irq), 1); chk("R9 no rst", 32'(rst_seen), 0);

    // R10: other source
    do_reset(); cur_req = "R10";
    wr_reg(4'h8, 32'h34);
    wr_reg(4'h0, 32'hC000_0003);
    step(12);
    chk("R10 irq held", 32'(irq), 1); chk("R10 no rst", 32'(rst_seen), 0);

    // R11: one-shot
    do_reset(); cur_req = "R11";
    wr_reg(4'h8, 32'h24);
    wr_reg(4'h0, 32'h8000_0003);
    step(3); chk("R11 irq", 32'(irq), 1);
    rd_reg(4'h0, v); chk("R11 run bit cleared", v, 32'h0000_0003);
    step(12); chk("R11 single expiry no rst", 32'(rst_seen), 0);

    // R12: stop
    do_reset(); cur_req = "R12";
    wr_reg(4'h8, 32'h24);
    wr_reg(4'h0, 32'hC000_0003);
    step(3); wr_reg(4'h4, 32'h4000_0000);
    wr_reg(4'h0, 32'h0);
    step(12);
    chk("R12 no irq after stop", 32'(irq), 0);
    chk("R12 no rst after stop", 32'(rst_seen), 0);

    // R14: sparse ticks, reload checked by the model every cycle
    do_reset(); cur_req = "R14";
    tick_div = 3;
    wr_reg(4'h8, 32'h24);
    wr_reg(4'h0, 32'hC000_0002);
    for (int k = 0; k < 4; k++) begin
      for (int w = 0; w < 30 && !irq; w++) step(1);
      wr_reg(4'h4, 32'h4000_0000);
    end
    step(30);
    chk("R14 strike after missed ack", 32'(srst_h), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule